// File: doc/BRIEF.md
# Outbound Address Window Translator

This block holds a small bank of outbound address windows and translates CPU-side addresses into PCI bus addresses. Software programs each window through a 32-bit register port. It sets where the window starts in CPU space, where it lands on the bus, how large it is as a power of two, and whether it is live. A separate lookup port takes a 64-bit CPU address. In the same cycle it reports whether an enabled window claims the address, which window claimed it, and the bus address that results.

Base and target values are held in 4 KiB page units. The size field is an exponent, so a window spans anything from 2 bytes up to the whole 64-bit space. When enabled windows overlap, the lowest-numbered window wins. A spare timer register in the same space is plain storage.

Top module: `owt_xlate`

## Requirements
- R1: After reset every register reads zero and no lookup hits (hit 0, window 0, bus address 0).
- R2: Window k (1 to NUM_WIN) uses the 32-byte group at register address k*0x20, selected by address bits [11:5]. Inside the group, the offset in bits [4:0] picks the register: 0x00 is the target page, 0x04 the extended target word, 0x08 the base page and 0x10 the attribute word. A write stores all 32 bits, and a read of the same address returns them.
- R3: The register at address 0x220 stores any 32-bit value written to it and returns it on read. It has no other effect.
- R4: Reads of any other address return zero, including offsets 0x0C and 0x14 to 0x1F inside a group, group 0, and groups above NUM_WIN. Writes to those addresses change no register and no lookup result.
- R5: An address A hits window k when attribute bit 31 is 1 and B <= A < B + S. Here B is the base page shifted left by 12 and S is 2 shifted left by attribute bits [5:0].
- R6: A window whose attribute bit 31 is 0 never hits, whatever its base and size.
- R7: On a hit, the bus address is (target page shifted left by 12) + (A - B), modulo 2^64. The extended target word does not affect it.
- R8: When several enabled windows contain A, the window with the lowest index is reported, and its translation is used.
- R9: On a miss the hit flag, window index and bus address are all zero.
- R10: Lookup is combinational. A register write takes effect on the lookup outputs in the cycle after the write's clock edge, and has no effect in the cycle the write is presented.
- R11: Size exponent 63 gives a 2^64-byte window: every address at or above its base hits, up to the top of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (12) | Register byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| lk_addr | input | ADDR_W (64) | CPU address to translate |
| lk_hit | output | 1 | An enabled window claims lk_addr |
| lk_win | output | IDX_W (3) | Index (1..NUM_WIN) of the claiming window, 0 on miss |
| lk_pci_addr | output | ADDR_W (64) | Translated bus address, 0 on miss |

## Verification
Read data and lookup results are combinational, so a new read address or lookup address is checked in the same cycle, at the falling edge after it is driven. A register write lands at the next rising edge. Its read-back and lookup effect are therefore checked at the falling edge one cycle after the write is presented, while the falling edge inside the write cycle confirms the old state is still visible. The bench's reference model applies writes at the same rising edges and compares read data and all lookup outputs at every falling edge, so every cycle's results are checked.

// File: rtl/owt_pkg.sv
package owt_pkg;
   localparam int REG_W      = 32;
   localparam int PAGE_SH    = 12;
   localparam int GRP_LSB    = 5;
   localparam int SZ_W       = 6;
   localparam int EN_BIT     = 31;

   localparam logic [4:0] OFF_TGT  = 5'h00;
   localparam logic [4:0] OFF_EXT  = 5'h04;
   localparam logic [4:0] OFF_BASE = 5'h08;
   localparam logic [4:0] OFF_ATTR = 5'h10;

   typedef struct packed {
      logic [REG_W-1:0] tgt;
      logic [REG_W-1:0] ext;
      logic [REG_W-1:0] base;
      logic [REG_W-1:0] attr;
   } owt_win_t;
endpackage

// File: rtl/owt_win_regs.sv
module owt_win_regs
   import owt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sel,
   input  logic [4:0]       wr_off,
   input  logic [REG_W-1:0] wr_data,
   input  logic [4:0]       rd_off,
   output logic [REG_W-1:0] rd_data,
   output owt_win_t         regs
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs <= '0;
      end else if (wr_sel) begin
         case (wr_off)
            OFF_TGT:  regs.tgt  <= wr_data;
            OFF_EXT:  regs.ext  <= wr_data;
            OFF_BASE: regs.base <= wr_data;
            OFF_ATTR: regs.attr <= wr_data;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (rd_off)
         OFF_TGT:  rd_data = regs.tgt;
         OFF_EXT:  rd_data = regs.ext;
         OFF_BASE: rd_data = regs.base;
         OFF_ATTR: rd_data = regs.attr;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/owt_match.sv
module owt_match
   import owt_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic             en,
   input  logic [SZ_W-1:0]  sz_exp,
   input  logic [REG_W-1:0] base_pg,
   input  logic [REG_W-1:0] tgt_pg,
   input  logic [ADDR_W-1:0] addr,
   output logic             hit,
   output logic [ADDR_W-1:0] pci_addr
);
   localparam int EW = ADDR_W + 1;

   logic [EW-1:0]     base_b;
   logic [EW-1:0]     addr_e;
   logic [EW-1:0]     off;
   logic [EW-1:0]     size_b;
   logic [ADDR_W-1:0] tgt_b;
   logic [SZ_W:0]     shamt;

   always_comb begin
      base_b = EW'({base_pg, {PAGE_SH{1'b0}}});
      tgt_b  = ADDR_W'({tgt_pg, {PAGE_SH{1'b0}}});
      addr_e = EW'(addr);
      off    = addr_e - base_b;
      shamt  = {1'b0, sz_exp} + 1'b1;
      if (int'(shamt) > ADDR_W) size_b = EW'(1) << ADDR_W;
      else                      size_b = EW'(1) << shamt;
      hit      = en && (addr_e >= base_b) && (off < size_b);
      pci_addr = tgt_b + off[ADDR_W-1:0];
   end
endmodule

// File: rtl/owt_prio.sv
module owt_prio #(
   parameter int N      = 4,
   parameter int ADDR_W = 64,
   parameter int IDX_W  = 3
) (
   input  logic [N-1:0]             hv,
   input  logic [N-1:0][ADDR_W-1:0] pa,
   output logic                     hit,
   output logic [IDX_W-1:0]         idx,
   output logic [ADDR_W-1:0]        pci
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      pci = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hv[i]) begin
            hit = 1'b1;
            idx = IDX_W'(i + 1);
            pci = pa[i];
         end
      end
   end
endmodule

// File: rtl/owt_xlate.sv
module owt_xlate
   import owt_pkg::*;
#(
   parameter int               NUM_WIN   = 4,
   parameter int               ADDR_W    = 64,
   parameter int               REG_AW    = 12,
   parameter logic [REG_AW-1:0] TIMER_OFF = 12'h220,
   parameter bit               TIMER_EN  = 1'b1,
   localparam int              IDX_W     = $clog2(NUM_WIN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_win,
   output logic [ADDR_W-1:0] lk_pci_addr
);
   localparam int GW = REG_AW - GRP_LSB;

   if (NUM_WIN < 1 || NUM_WIN > 7) begin : g_bad_num
      $error("owt_xlate: NUM_WIN must be 1..7");
   end
   if (ADDR_W < REG_W + PAGE_SH || ADDR_W > 64) begin : g_bad_aw
      $error("owt_xlate: ADDR_W must be 44..64");
   end
   if (REG_AW < 8) begin : g_bad_raw
      $error("owt_xlate: REG_AW too small");
   end
   if (TIMER_OFF[4:0] != 5'd0 || int'(TIMER_OFF >> GRP_LSB) <= NUM_WIN) begin : g_bad_tmr
      $error("owt_xlate: TIMER_OFF collides with window groups");
   end

   logic [GW-1:0] grp;
   assign grp = reg_addr[REG_AW-1:GRP_LSB];

   logic [NUM_WIN-1:0]             hv;
   logic [NUM_WIN-1:0][ADDR_W-1:0] pa;
   logic [NUM_WIN-1:0][REG_W-1:0]  win_rd;

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
      owt_win_t   regs;
      logic       sel;
      assign sel = (grp == GW'(k + 1));

      owt_win_regs u_regs (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_sel  (reg_wr && sel),
         .wr_off  (reg_addr[4:0]),
         .wr_data (reg_wdata),
         .rd_off  (reg_addr[4:0]),
         .rd_data (win_rd[k]),
         .regs    (regs)
      );

      owt_match #(.ADDR_W(ADDR_W)) u_match (
         .en       (regs.attr[EN_BIT]),
         .sz_exp   (regs.attr[SZ_W-1:0]),
         .base_pg  (regs.base),
         .tgt_pg   (regs.tgt),
         .addr     (lk_addr),
         .hit      (hv[k]),
         .pci_addr (pa[k])
      );
   end

   owt_prio #(.N(NUM_WIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_prio (
      .hv  (hv),
      .pa  (pa),
      .hit (lk_hit),
      .idx (lk_win),
      .pci (lk_pci_addr)
   );

   logic [REG_W-1:0] timer_q;
   logic             timer_sel;
   assign timer_sel = (reg_addr == TIMER_OFF);

   if (TIMER_EN) begin : g_timer
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  timer_q <= '0;
         else if (reg_wr && timer_sel) timer_q <= reg_wdata;
      end
   end else begin : g_no_timer
      assign timer_q = '0;
   end

   always_comb begin
      reg_rdata = '0;
      for (int k = 0; k < NUM_WIN; k++) begin
         if (grp == GW'(k + 1)) reg_rdata = win_rd[k];
      end
      if (timer_sel) reg_rdata = timer_q;
   end
endmodule

// File: rtl/owt_xlate_chk.sv
module owt_xlate_chk #(
   parameter int               NUM_WIN   = 4,
   parameter int               ADDR_W    = 64,
   parameter int               REG_AW    = 12,
   parameter logic [REG_AW-1:0] TIMER_OFF = 12'h220,
   parameter int               IDX_W     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [REG_AW-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic [ADDR_W-1:0] lk_addr,
   input logic              lk_hit,
   input logic [IDX_W-1:0]  lk_win,
   input logic [ADDR_W-1:0] lk_pci_addr
);
   function automatic bit is_win_reg(logic [REG_AW-1:0] a);
      int g;
      g = int'(a >> 5);
      return (g >= 1) && (g <= NUM_WIN) &&
             (a[4:0] == 5'h00 || a[4:0] == 5'h04 || a[4:0] == 5'h08 || a[4:0] == 5'h10);
   endfunction

   logic mapped;
   assign mapped = is_win_reg(reg_addr) || (reg_addr == TIMER_OFF);

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (reg_rdata == 32'd0 && !lk_hit));

   assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && is_win_reg(reg_addr)) |=>
      (reg_addr != $past(reg_addr) || reg_rdata == $past(reg_wdata)));

   assert_timer_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == TIMER_OFF) |=>
      (reg_addr != TIMER_OFF || reg_rdata == $past(reg_wdata)));

   assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> reg_rdata == 32'd0);

   assert_hit_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_win != '0 && int'(lk_win) <= NUM_WIN));

   assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_win == '0 && lk_pci_addr == '0));

   assert_lookup_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reg_wr) && $stable(lk_addr)) |->
      ($stable(lk_hit) && $stable(lk_win) && $stable(lk_pci_addr)));
endmodule

bind owt_xlate owt_xlate_chk #(
   .NUM_WIN   (NUM_WIN),
   .ADDR_W    (ADDR_W),
   .REG_AW    (REG_AW),
   .TIMER_OFF (TIMER_OFF),
   .IDX_W     (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .lk_addr     (lk_addr),
   .lk_hit      (lk_hit),
   .lk_win      (lk_win),
   .lk_pci_addr (lk_pci_addr)
);

// File: tb/tb_owt_xlate.sv
module tb_owt_xlate;
   localparam int NW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] lk_addr = '0;
   logic        lk_hit;
   logic [2:0]  lk_win;
   logic [63:0] lk_pci_addr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   owt_xlate dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
      .lk_hit(lk_hit), .lk_win(lk_win), .lk_pci_addr(lk_pci_addr)
   );

   // behavioural reference model
   logic [31:0] m_tgt [1:NW];
   logic [31:0] m_ext [1:NW];
   logic [31:0] m_base[1:NW];
   logic [31:0] m_attr[1:NW];
   logic [31:0] m_tmr;

   task automatic m_clear();
      for (int k = 1; k <= NW; k++) begin
         m_tgt[k] = 0; m_ext[k] = 0; m_base[k] = 0; m_attr[k] = 0;
      end
      m_tmr = 0;
   endtask

   function automatic logic [31:0] m_read(logic [11:0] a);
      int g;
      g = int'(a >> 5);
      if (a == 12'h220) return m_tmr;
      if (g < 1 || g > NW) return 0;
      case (a[4:0])
         5'h00: return m_tgt[g];
         5'h04: return m_ext[g];
         5'h08: return m_base[g];
         5'h10: return m_attr[g];
         default: return 0;
      endcase
   endfunction

   task automatic m_lookup(input logic [63:0] a, output logic h,
                           output logic [2:0] w, output logic [63:0] p);
      logic [64:0] b, s, d;
      h = 0; w = 0; p = 0;
      for (int k = 1; k <= NW; k++) begin
         b = {21'd0, m_base[k], 12'd0};
         s = 65'd2 << m_attr[k][5:0];
         d = {1'b0, a} - b;
         if (!h && m_attr[k][31] && {1'b0, a} >= b && d < s) begin
            h = 1; w = 3'(k);
            p = {20'd0, m_tgt[k], 12'd0} + d[63:0];
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) m_clear();
      else if (reg_wr) begin
         if (reg_addr == 12'h220) m_tmr = reg_wdata;
         else if (reg_addr[11:8] == 0 && reg_addr[7:5] >= 1 && int'(reg_addr[7:5]) <= NW) begin
            case (reg_addr[4:0])
               5'h00: m_tgt[reg_addr[7:5]]  = reg_wdata;
               5'h04: m_ext[reg_addr[7:5]]  = reg_wdata;
               5'h08: m_base[reg_addr[7:5]] = reg_wdata;
               5'h10: m_attr[reg_addr[7:5]] = reg_wdata;
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      logic h; logic [2:0] w; logic [63:0] p; logic [31:0] r;
      if (rst_n && !done) begin
         m_lookup(lk_addr, h, w, p);
         r = m_read(reg_addr);
         total++;
         if (lk_hit !== h || lk_win !== w || lk_pci_addr !== p || reg_rdata !== r) begin
            bad++;
            $display("FAIL R10 model compare: got hit=%0b win=%0d pci=%h rd=%h exp hit=%0b win=%0d pci=%h rd=%h",
                     lk_hit, lk_win, lk_pci_addr, reg_rdata, h, w, p, r);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
      reg_addr = a;
      @(negedge clk);
      total++;
      if (reg_rdata !== e) begin
         bad++;
         $display("FAIL %s read %h: got %h exp %h", tag, a, reg_rdata, e);
      end
   endtask

   task automatic lk_chk(input logic [63:0] a, input logic h, input logic [2:0] w,
                         input logic [63:0] p, input string tag);
      lk_addr = a;
      @(negedge clk);
      total++;
      if (lk_hit !== h || lk_win !== w || lk_pci_addr !== p) begin
         bad++;
         $display("FAIL %s lookup %h: got hit=%0b win=%0d pci=%h exp hit=%0b win=%0d pci=%h",
                  tag, a, lk_hit, lk_win, lk_pci_addr, h, w, p);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      rd_chk(12'h020, 32'h0, "R1");
      rd_chk(12'h220, 32'h0, "R1");
      lk_chk(64'h0, 0, 0, 64'h0, "R1");

      // R2 programming and read-back of window 1
      wr(12'h020, 32'h0008_0000);
      wr(12'h024, 32'hDEAD_BEEF);
      wr(12'h028, 32'h0001_0000);
      rd_chk(12'h020, 32'h0008_0000, "R2");
      rd_chk(12'h024, 32'hDEAD_BEEF, "R2");
      rd_chk(12'h028, 32'h0001_0000, "R2");

      // R10 enable takes effect only after the write edge
      lk_addr = 64'h1000_0000;
      @(posedge clk); #1;
      reg_wr = 1; reg_addr = 12'h030; reg_wdata = 32'h8000_000F;
      @(negedge clk);
      total++;
      if (lk_hit !== 1'b0) begin
         bad++; $display("FAIL R10 hit during write cycle: got %0b exp 0", lk_hit);
      end
      @(posedge clk); #1; reg_wr = 0;
      lk_chk(64'h1000_0000, 1, 1, 64'h8000_0000, "R10");
      rd_chk(12'h030, 32'h8000_000F, "R2");

      // R5 / R7 / R9 window edges; extended word has no effect (R7)
      lk_chk(64'h1000_FFFF, 1, 1, 64'h8000_FFFF, "R5");
      lk_chk(64'h1000_0123, 1, 1, 64'h8000_0123, "R7");
      lk_chk(64'h1001_0000, 0, 0, 64'h0, "R9");
      lk_chk(64'h0FFF_FFFF, 0, 0, 64'h0, "R5");

      // R6 disabled window never hits
      wr(12'h030, 32'h0000_000F);
      lk_chk(64'h1000_0000, 0, 0, 64'h0, "R6");
      wr(12'h030, 32'h8000_000F);
      lk_chk(64'h1000_0010, 1, 1, 64'h8000_0010, "R6");

      // R3 timer storage
      wr(12'h220, 32'hA5A5_5A5A);
      rd_chk(12'h220, 32'hA5A5_5A5A, "R3");
      lk_chk(64'h1000_0010, 1, 1, 64'h8000_0010, "R3");

      // R4 unmapped writes ignored, reads zero
      wr(12'h02C, 32'hFFFF_FFFF);
      wr(12'h000, 32'hFFFF_FFFF);
      wr(12'h0A0, 32'hFFFF_FFFF);
      wr(12'h240, 32'hFFFF_FFFF);
      wr(12'h034, 32'hFFFF_FFFF);
      rd_chk(12'h02C, 32'h0, "R4");
      rd_chk(12'h000, 32'h0, "R4");
      rd_chk(12'h0A0, 32'h0, "R4");
      rd_chk(12'h240, 32'h0, "R4");
      rd_chk(12'h020, 32'h0008_0000, "R4");
      rd_chk(12'h028, 32'h0001_0000, "R4");
      rd_chk(12'h030, 32'h8000_000F, "R4");
      rd_chk(12'h220, 32'hA5A5_5A5A, "R4");
      lk_chk(64'h1000_0004, 1, 1, 64'h8000_0004, "R4");

      // R8 overlap priority with window 2
      wr(12'h040, 32'h0020_0000);
      wr(12'h048, 32'h0001_0000);
      wr(12'h050, 32'h8000_001F);
      lk_chk(64'h1000_0004, 1, 1, 64'h8000_0004, "R8");
      lk_chk(64'h1002_0000, 1, 2, 64'h2_0002_0000, "R8");
      wr(12'h030, 32'h0);
      lk_chk(64'h1000_0004, 1, 2, 64'h2_0000_0004, "R8");

      // R11 full-space window 4
      wr(12'h088, 32'hFFFF_FFFF);
      wr(12'h090, 32'h8000_003F);
      lk_chk(64'hFFFF_FFFF_FFFF_FFFF, 1, 4, 64'hFFFF_F000_0000_0FFF, "R11");
      lk_chk(64'h0000_0FFF_FFFF_EFFF, 0, 0, 64'h0, "R11");
      wr(12'h080, 32'h0010_0000);
      lk_chk(64'hFFFF_FFFF_FFFF_FFFF, 1, 4, 64'hFFFF_F001_0000_0FFF, "R7");

      repeat (2) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule